// File: doc/BRIEF.md
# Timed-Access Write Guard

This block keeps a group of critical control bits (watchdog enables, reset-cause flags and similar) from being changed by stray software writes. Software unlocks the guard by writing a two-byte key to one dedicated guard address: first AAh, then 55h. The second byte must arrive within a short count of machine-cycle ticks after the first. A correct key opens a write window for a fixed number of machine cycles. While the window is open, the guard raises a protected-write enable. Any register that holds critical bits uses this enable to qualify its writes.

The guard sits on a simple register bus made of a write strobe with address and data and a read port with address. It also takes a machine-cycle tick. The protected registers are outside its scope, so one small demonstration register stands in for them. Its upper nibble is protected and its lower nibble is writable at any time.

The sequencer has three named states. IDLE waits for the first key. ARMED has seen AAh and counts ticks while it waits for 55h. OPEN is the write window. The transitions are:
- IDLE to ARMED on a guard write of AAh.
- ARMED to OPEN on a guard write of 55h.
- ARMED to IDLE on any other guard write, or on the fourth tick.
- OPEN to ARMED on a guard write of AAh.
- OPEN to IDLE on any other guard write, on a write to the protected register, or on the third tick.

Top module: `ta_guard`

## Requirements
- R1: After reset, the sequencer is in IDLE, `prot_we` is 0 and `ctl_q` is 00h.
- R2: A write of AAh to the guard address (3Ch), followed by a write of 55h to the same address, raises `prot_we` in the cycle after the 55h write.
- R3: The 55h key is accepted only if fewer than 4 ticks have been completed since the AAh write. A tick in the same cycle as the AAh write is not counted. A 55h write in the same cycle as the fourth tick is still accepted. After the fourth tick with no key, the sequencer returns to IDLE, and a later 55h does not open the window.
- R4: The window lasts 3 ticks. `prot_we` stays high through the first two ticks after opening and drops after the third. A write in the same cycle as the third tick is still inside the window.
- R5: A write to the demonstration register (3Dh) while `prot_we` is high updates its protected bits (bits 7:4). That write also closes the window, so only one protected write is allowed per unlock.
- R6: A write to 3Dh while `prot_we` is low leaves bits 7:4 of `ctl_q` unchanged.
- R7: Bits 3:0 of `ctl_q` take the written data on every write to 3Dh, whether or not the window is open.
- R8: Any guard write other than the expected key returns the sequencer to IDLE. This includes AAh while ARMED. A guard write of AAh while OPEN closes the window and re-arms the sequencer.
- R9: When `rd_en` is high, a read of 3Ch returns FFh, a read of 3Dh returns `ctl_q`, and a read of any other address returns 00h. Reads never change the sequencer state.
- R10: Writes to addresses other than 3Ch and 3Dh do not change the sequencer state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mc_tick | input | 1 | One-cycle pulse per machine cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Read data, combinational |
| prot_we | output | 1 | Protected-write enable, high while the window is open |
| ctl_q | output | 8 | Demonstration register contents |

## Verification
The machine-cycle tick can land in the same cycle as a bus write. That write may be the 55h key arriving just as the fourth tick would expire the arming, or a protected write arriving just as the third tick would close the window. The stimulus table provokes both collisions on purpose by raising the tick together with the write. It then judges the result from `prot_we` and from the protected nibble of `ctl_q`: in both cases the write must win. The same table also places the key one tick too late, to confirm that the expiry still applies when no write competes with it.

// File: rtl/ta_pkg.sv
package ta_pkg;
    typedef enum logic [1:0] {
        TA_IDLE  = 2'd0,
        TA_ARMED = 2'd1,
        TA_OPEN  = 2'd2
    } ta_state_e;
endpackage

// File: rtl/ta_seq.sv
module ta_seq
    import ta_pkg::*;
#(
    parameter int              DATA_W    = 8,
    parameter logic [DATA_W-1:0] KEY1    = 8'hAA,
    parameter logic [DATA_W-1:0] KEY2    = 8'h55,
    parameter int              GAP_LIMIT = 4,
    parameter int              WIN_CYC   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              key_wr,
    input  logic [DATA_W-1:0] key_data,
    input  logic              prot_wr,
    output logic              open_o
);
    localparam int CNT_MAX = (GAP_LIMIT > WIN_CYC) ? GAP_LIMIT : WIN_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] GAP_END = CNT_W'(GAP_LIMIT - 1);
    localparam logic [CNT_W-1:0] WIN_END = CNT_W'(WIN_CYC - 1);

    ta_state_e        state, state_nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= TA_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    // Transitions: a bus write takes priority over a tick in the same cycle
    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        unique case (state)
            TA_IDLE: begin
                cnt_nxt = '0;
                if (key_wr && key_data == KEY1) state_nxt = TA_ARMED;
            end
            TA_ARMED: begin
                if (key_wr) begin
                    cnt_nxt   = '0;
                    state_nxt = (key_data == KEY2) ? TA_OPEN : TA_IDLE;
                end else if (tick) begin
                    if (cnt == GAP_END) begin
                        state_nxt = TA_IDLE;
                        cnt_nxt   = '0;
                    end else begin
                        cnt_nxt = cnt + 1'b1;
                    end
                end
            end
            TA_OPEN: begin
                if (key_wr) begin
                    cnt_nxt   = '0;
                    state_nxt = (key_data == KEY1) ? TA_ARMED : TA_IDLE;
                end else if (prot_wr) begin
                    cnt_nxt   = '0;
                    state_nxt = TA_IDLE;
                end else if (tick) begin
                    if (cnt == WIN_END) begin
                        state_nxt = TA_IDLE;
                        cnt_nxt   = '0;
                    end else begin
                        cnt_nxt = cnt + 1'b1;
                    end
                end
            end
            default: begin
                state_nxt = TA_IDLE;
                cnt_nxt   = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        open_o = (state == TA_OPEN);
    end
endmodule

// File: rtl/ta_demo_reg.sv
module ta_demo_reg #(
    parameter int                DATA_W    = 8,
    parameter logic [DATA_W-1:0] PROT_MASK = 8'hF0,
    parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              prot_ok,
    output logic [DATA_W-1:0] q
);
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        logic bit_we;
        if (PROT_MASK[b]) begin : g_prot
            assign bit_we = wr & prot_ok;
        end else begin : g_free
            assign bit_we = wr;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      q[b] <= RESET_VAL[b];
            else if (bit_we) q[b] <= wdata[b];
        end
    end
endmodule

// File: rtl/ta_guard.sv
module ta_guard #(
    parameter int                ADDR_W      = 8,
    parameter int                DATA_W      = 8,
    parameter logic [ADDR_W-1:0] GUARD_ADDR  = 8'h3C,
    parameter logic [ADDR_W-1:0] DEMO_ADDR   = 8'h3D,
    parameter logic [DATA_W-1:0] KEY1        = 8'hAA,
    parameter logic [DATA_W-1:0] KEY2        = 8'h55,
    parameter int                GAP_LIMIT   = 4,
    parameter int                WIN_CYC     = 3,
    parameter logic [DATA_W-1:0] PROT_MASK   = 8'hF0,
    parameter logic [DATA_W-1:0] GUARD_RDVAL = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mc_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              prot_we,
    output logic [DATA_W-1:0] ctl_q
);
    logic key_wr;
    logic demo_wr;

    assign key_wr  = wr_en && (wr_addr == GUARD_ADDR);
    assign demo_wr = wr_en && (wr_addr == DEMO_ADDR);

    ta_seq #(
        .DATA_W   (DATA_W),
        .KEY1     (KEY1),
        .KEY2     (KEY2),
        .GAP_LIMIT(GAP_LIMIT),
        .WIN_CYC  (WIN_CYC)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (mc_tick),
        .key_wr  (key_wr),
        .key_data(wr_data),
        .prot_wr (demo_wr),
        .open_o  (prot_we)
    );

    ta_demo_reg #(
        .DATA_W   (DATA_W),
        .PROT_MASK(PROT_MASK),
        .RESET_VAL('0)
    ) u_demo (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (demo_wr),
        .wdata  (wr_data),
        .prot_ok(prot_we),
        .q      (ctl_q)
    );

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            if (rd_addr == GUARD_ADDR)     rd_data = GUARD_RDVAL;
            else if (rd_addr == DEMO_ADDR) rd_data = ctl_q;
        end
    end
endmodule

// File: rtl/ta_guard_chk.sv
module ta_guard_chk #(
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 8,
    parameter logic [ADDR_W-1:0] GUARD_ADDR = 8'h3C,
    parameter logic [ADDR_W-1:0] DEMO_ADDR = 8'h3D,
    parameter logic [DATA_W-1:0] KEY1      = 8'hAA,
    parameter logic [DATA_W-1:0] KEY2      = 8'h55,
    parameter int                WIN_CYC   = 3,
    parameter logic [DATA_W-1:0] PROT_MASK = 8'hF0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mc_tick,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              prot_we,
    input logic [DATA_W-1:0] ctl_q
);
    logic [7:0] open_ticks;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        open_ticks <= '0;
        else if (!prot_we) open_ticks <= '0;
        else if (mc_tick)  open_ticks <= open_ticks + 8'd1;
    end

    // R2
    open_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prot_we) |-> $past(wr_en && wr_addr == GUARD_ADDR && wr_data == KEY2));

    // R4
    window_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prot_we |-> (open_ticks < 8'(WIN_CYC)));

    // R5
    single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_we && wr_en && wr_addr == DEMO_ADDR) |=> !prot_we);

    // R6
    prot_bits_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctl_q & PROT_MASK) |-> $past(prot_we && wr_en && wr_addr == DEMO_ADDR));

    // R7
    free_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == DEMO_ADDR) |=> ((ctl_q & ~PROT_MASK) == ($past(wr_data) & ~PROT_MASK)));

    // R8
    bad_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == GUARD_ADDR && wr_data != KEY1 && wr_data != KEY2) |=> !prot_we);
endmodule

bind ta_guard ta_guard_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .GUARD_ADDR(GUARD_ADDR),
    .DEMO_ADDR (DEMO_ADDR),
    .KEY1      (KEY1),
    .KEY2      (KEY2),
    .WIN_CYC   (WIN_CYC),
    .PROT_MASK (PROT_MASK)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .mc_tick(mc_tick),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .prot_we(prot_we),
    .ctl_q  (ctl_q)
);

// File: tb/ta_guard_tb.sv
module ta_guard_tb;
    localparam logic [7:0] GA = 8'h3C;
    localparam logic [7:0] DM = 8'h3D;
    localparam logic [7:0] OT = 8'h40;
    localparam int NV = 38;

    // {req[3:0], wr_en, addr[7:0], data[7:0], tick, exp_we, exp_ctl[7:0]}
    localparam logic [30:0] VEC [0:NV-1] = '{
        {4'd7,  1'b1, DM, 8'hFF, 1'b0, 1'b0, 8'h0F}, // R7 R6 locked write
        {4'd2,  1'b1, GA, 8'hAA, 1'b0, 1'b0, 8'h0F},
        {4'd3,  1'b0, OT, 8'h00, 1'b1, 1'b0, 8'h0F},
        {4'd2,  1'b1, GA, 8'h55, 1'b0, 1'b1, 8'h0F}, // R2 opens
        {4'd4,  1'b0, OT, 8'h00, 1'b1, 1'b1, 8'h0F},
        {4'd5,  1'b1, DM, 8'hA5, 1'b0, 1'b0, 8'hA5}, // R5 one write, closes
        {4'd6,  1'b1, DM, 8'h3C, 1'b0, 1'b0, 8'hAC}, // R6
        {4'd8,  1'b1, GA, 8'hAA, 1'b0, 1'b0, 8'hAC},
        {4'd8,  1'b1, GA, 8'h12, 1'b0, 1'b0, 8'hAC}, // R8 wrong key
        {4'd8,  1'b1, GA, 8'h55, 1'b0, 1'b0, 8'hAC},
        {4'd6,  1'b1, DM, 8'h00, 1'b0, 1'b0, 8'hA0},
        {4'd3,  1'b1, GA, 8'hAA, 1'b0, 1'b0, 8'hA0},
        {4'd3,  1'b0, OT, 8'h00, 1'b1, 1'b0, 8'hA0},
        {4'd3,  1'b0, OT, 8'h00, 1'b1, 1'b0, 8'hA0},
        {4'd3,  1'b0, OT, 8'h00, 1'b1, 1'b0, 8'hA0},
        {4'd3,  1'b0, OT, 8'h00, 1'b1, 1'b0, 8'hA0}, // R3 fourth tick expires
        {4'd3,  1'b1, GA, 8'h55, 1'b0, 1'b0, 8'hA0},
        {4'd3,  1'b1, DM, 8'hFF, 1'b0, 1'b0, 8'hAF},
        {4'd3,  1'b1, GA, 8'hAA, 1'b1, 1'b0, 8'hAF},
        {4'd3,  1'b0, OT, 8'h00, 1'b1, 1'b0, 8'hAF},
        {4'd3,  1'b0, OT, 8'h00, 1'b1, 1'b0, 8'hAF},
        {4'd3,  1'b0, OT, 8'h00, 1'b1, 1'b0, 8'hAF},
        {4'd3,  1'b1, GA, 8'h55, 1'b1, 1'b1, 8'hAF}, // R3 key beats 4th tick
        {4'd4,  1'b0, OT, 8'h00, 1'b1, 1'b1, 8'hAF},
        {4'd4,  1'b0, OT, 8'h00, 1'b1, 1'b1, 8'hAF},
        {4'd4,  1'b0, OT, 8'h00, 1'b1, 1'b0, 8'hAF}, // R4 third tick closes
        {4'd4,  1'b1, DM, 8'h5A, 1'b0, 1'b0, 8'hAA},
        {4'd2,  1'b1, GA, 8'hAA, 1'b0, 1'b0, 8'hAA},
        {4'd2,  1'b1, GA, 8'h55, 1'b0, 1'b1, 8'hAA},
        {4'd4,  1'b0, OT, 8'h00, 1'b1, 1'b1, 8'hAA},
        {4'd4,  1'b0, OT, 8'h00, 1'b1, 1'b1, 8'hAA},
        {4'd4,  1'b1, DM, 8'h53, 1'b1, 1'b0, 8'h53}, // R4 write beats 3rd tick
        {4'd2,  1'b1, GA, 8'hAA, 1'b0, 1'b0, 8'h53},
        {4'd2,  1'b1, GA, 8'h55, 1'b0, 1'b1, 8'h53},
        {4'd8,  1'b1, GA, 8'hAA, 1'b0, 1'b0, 8'h53}, // R8 re-arm from open
        {4'd8,  1'b1, GA, 8'h55, 1'b0, 1'b1, 8'h53},
        {4'd10, 1'b1, OT, 8'hAA, 1'b0, 1'b1, 8'h53}, // R10 other address
        {4'd8,  1'b1, GA, 8'h00, 1'b0, 1'b0, 8'h53}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mc_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       prot_we;
    logic [7:0] ctl_q;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    ta_guard u_dut (
        .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .prot_we(prot_we), .ctl_q(ctl_q)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic we, input logic [7:0] a, input logic [7:0] d, input logic t);
        @(negedge clk);
        wr_en = we; wr_addr = a; wr_data = d; mc_tick = t;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1", {7'd0, prot_we, ctl_q}, 16'h0000);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][26], VEC[i][25:18], VEC[i][17:10], VEC[i][9]);
            check($sformatf("R%0d vec %0d", VEC[i][30:27], i),
                  {7'd0, prot_we, ctl_q}, {7'd0, VEC[i][8], VEC[i][7:0]});
        end
        step(1'b0, OT, 8'h00, 1'b0);

        // R9 read values
        @(negedge clk);
        rd_en = 1'b1; rd_addr = GA; #1;
        check("R9 guard read", {8'd0, rd_data}, 16'h00FF);
        rd_addr = DM; #1;
        check("R9 demo read", {8'd0, rd_data}, 16'h0053);
        rd_addr = OT; #1;
        check("R9 other read", {8'd0, rd_data}, 16'h0000);
        rd_en = 1'b0; rd_addr = GA; #1;
        check("R9 read idle", {8'd0, rd_data}, 16'h0000);

        // R9 reads between keys leave the sequence intact
        step(1'b1, GA, 8'hAA, 1'b0);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b1; rd_addr = GA;
        @(posedge clk); #1;
        rd_en = 1'b0;
        step(1'b1, GA, 8'h55, 1'b0);
        check("R9 read keeps sequence", {15'd0, prot_we}, 16'h0001);

        // R1 reset in the middle of an open window
        @(negedge clk);
        wr_en = 1'b0; rst_n = 1'b0; #1;
        check("R1 mid-window reset", {7'd0, prot_we, ctl_q}, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b1, GA, 8'h55, 1'b0);
        check("R1 idle after reset", {15'd0, prot_we}, 16'h0000);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule